// File: doc/BRIEF.md
# Transmit Source Arbiter with Skip Scheduling

This block decides what the transmit path of a multi-lane serial link puts on the wire next. Four kinds of frame compete: link-layer control packets, transaction packets, logical idle frames and periodic skip ordered sets. Two ready/valid queues offer the packets. A link-up flag and a symbol-time tick come from the link controller. The arbiter hands a source code and a one-cycle start strobe to a downstream framer, and the framer answers with a done pulse when the frame has left.

After the link comes up, a start-up gate holds back transaction packets until a fixed number of control packets has gone out. After that the two queues take turns. A queue that does not hold the turn may still send when the other queue is empty, and the turn stays where it was. Every packet is followed by one idle frame. A symbol counter schedules skip ordered sets, and a set that is due goes ahead of everything else at the next selection. While the link is down the arbiter produces only idle frames and clears all its start-up and scheduling state.

Top module: `tx_src_arb`

## Requirements
- R1: While rst_ni is low, start_o, ctl_ready_o and txn_ready_o are low. The first selection happens at the first clock edge after reset is released.
- R2: src_o uses these codes: 0 idle frame, 1 control packet, 2 transaction packet, 3 skip set. start_o is high for exactly one cycle per selection, and src_o changes only in that cycle. Each later selection is made at a clock edge where done_i is high and start_o is low, so done_i is ignored during the start cycle.
- R3: After link-up, a transaction packet is not selected until CTL_GATE (default 5) control packets have been selected. While the gate is closed, an empty control queue yields an idle frame.
- R4: Once the gate is open, the turn alternates. A control packet sent on its own turn passes the turn to transaction packets, and a transaction packet sent on its turn passes it back. The first turn after the gate opens belongs to transaction packets. With both queues empty, an idle frame is selected.
- R5: If only the queue without the turn has a packet, that packet is selected and the turn does not change.
- R6: After every control or transaction packet, one idle frame is selected before the next packet. A skip set may come between the packet and that idle frame.
- R7: The symbol counter counts sym_tick_i while the link is up and saturates at SKP_INTERVAL (default 1450). At a selection where it equals SKP_INTERVAL, a skip set (code 3) is chosen ahead of the idle obligation and both queues, and the counter clears to 0. A tick at that same edge is dropped.
- R8: While link_up_i is low, every selection is an idle frame, the symbol counter is held at 0, the idle obligation and the gate count are cleared, and the turn returns to transaction packets.
- R9: ctl_ready_o (or txn_ready_o) is high exactly in the start cycle of a control (or transaction) selection, and a queue pops when ready and valid are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_up_i | input | 1 | Link initialised |
| sym_tick_i | input | 1 | One pulse per transmitted symbol time |
| ctl_valid_i | input | 1 | Control queue has a packet |
| ctl_ready_o | output | 1 | Control queue pop |
| txn_valid_i | input | 1 | Transaction queue has a packet |
| txn_ready_o | output | 1 | Transaction queue pop |
| done_i | input | 1 | Framer finished the current frame |
| start_o | output | 1 | New selection strobe |
| src_o | output | 2 | Selected source code |

## Verification
A selection is made at a clock edge. Its start_o, src_o and ready outputs appear after that one register and are due in the cycle that follows. The bench's model advances at the same edge, using the same sampled inputs. Inputs are driven 2 ns after each rising edge, and outputs are compared at the falling edge, so every check lands in the cycle its result is due. The framer model answers done after 1 to 4 cycles or holds done high, so both the earliest allowed reselection and an ignored done in the start cycle are covered.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_CTL  = 2'd1,
    SRC_TXN  = 2'd2,
    SRC_SKP  = 2'd3
  } src_e;
endpackage

// File: rtl/tx_arb_skp_timer.sv
module tx_arb_skp_timer #(
  parameter int unsigned SKP_INTERVAL = 1450
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic due_o
);
  localparam int unsigned CW = $clog2(SKP_INTERVAL + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SKP_INTERVAL);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || !link_i)       cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign due_o = (cnt_q == LIMIT);
endmodule

// File: rtl/tx_arb_gate.sv
module tx_arb_gate #(
  parameter int unsigned CTL_GATE = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_i,
  input  logic inc_i,
  output logic open_o
);
  localparam int unsigned GW = $clog2(CTL_GATE + 1);
  localparam logic [GW-1:0] GMAX = GW'(CTL_GATE);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!link_i)               cnt_q <= '0;
    else if (inc_i && cnt_q != GMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = (cnt_q == GMAX);
endmodule

// File: rtl/tx_arb_pick.sv
module tx_arb_pick
  import tx_arb_pkg::*;
(
  input  logic link_i,
  input  logic skp_due_i,
  input  logic idle_owed_i,
  input  logic gate_open_i,
  input  logic turn_txn_i,
  input  logic ctl_valid_i,
  input  logic txn_valid_i,
  output src_e src_o,
  output logic turn_txn_o
);
  always_comb begin
    src_o      = SRC_IDLE;
    turn_txn_o = turn_txn_i;
    if (!link_i) begin
      src_o = SRC_IDLE;
    end else if (skp_due_i) begin
      src_o = SRC_SKP;
    end else if (idle_owed_i) begin
      src_o = SRC_IDLE;
    end else if (!gate_open_i) begin
      if (ctl_valid_i) src_o = SRC_CTL;
    end else if (turn_txn_i) begin
      if (txn_valid_i) begin
        src_o      = SRC_TXN;
        turn_txn_o = 1'b0;
      end else if (ctl_valid_i) begin
        src_o = SRC_CTL;  // off-turn, turn kept
      end
    end else begin
      if (ctl_valid_i) begin
        src_o      = SRC_CTL;
        turn_txn_o = 1'b1;
      end else if (txn_valid_i) begin
        src_o = SRC_TXN;  // off-turn, turn kept
      end
    end
  end
endmodule

// File: rtl/tx_src_arb.sv
module tx_src_arb
  import tx_arb_pkg::*;
#(
  parameter int unsigned SKP_INTERVAL = 1450,
  parameter int unsigned CTL_GATE     = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       link_up_i,
  input  logic       sym_tick_i,
  input  logic       ctl_valid_i,
  output logic       ctl_ready_o,
  input  logic       txn_valid_i,
  output logic       txn_ready_o,
  input  logic       done_i,
  output logic       start_o,
  output logic [1:0] src_o
);
  logic busy_q, start_q, idle_owed_q, turn_txn_q;
  src_e src_q, pick_src;
  logic pick_turn, decide, skp_due, gate_open, pick_pkt;

  assign decide   = !busy_q || (done_i && !start_q);
  assign pick_pkt = (pick_src == SRC_CTL) || (pick_src == SRC_TXN);

  tx_arb_skp_timer #(.SKP_INTERVAL(SKP_INTERVAL)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .link_i (link_up_i),
    .tick_i (sym_tick_i),
    .clr_i  (decide && pick_src == SRC_SKP),
    .due_o  (skp_due)
  );

  tx_arb_gate #(.CTL_GATE(CTL_GATE)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .link_i (link_up_i),
    .inc_i  (decide && pick_src == SRC_CTL),
    .open_o (gate_open)
  );

  tx_arb_pick u_pick (
    .link_i      (link_up_i),
    .skp_due_i   (skp_due),
    .idle_owed_i (idle_owed_q),
    .gate_open_i (gate_open),
    .turn_txn_i  (turn_txn_q),
    .ctl_valid_i (ctl_valid_i),
    .txn_valid_i (txn_valid_i),
    .src_o       (pick_src),
    .turn_txn_o  (pick_turn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      start_q     <= 1'b0;
      src_q       <= SRC_IDLE;
      idle_owed_q <= 1'b0;
      turn_txn_q  <= 1'b1;
    end else begin
      start_q <= decide;
      if (decide) begin
        busy_q      <= 1'b1;
        src_q       <= pick_src;
        turn_txn_q  <= pick_turn;
        // a skip set does not discharge the idle obligation
        idle_owed_q <= pick_pkt || (idle_owed_q && pick_src == SRC_SKP);
      end
      if (!link_up_i) begin
        idle_owed_q <= 1'b0;
        turn_txn_q  <= 1'b1;
      end
    end
  end

  assign start_o     = start_q;
  assign src_o       = src_q;
  assign ctl_ready_o = start_q && (src_q == SRC_CTL);
  assign txn_ready_o = start_q && (src_q == SRC_TXN);
endmodule

// File: rtl/tx_src_arb_chk.sv
module tx_src_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       link_up_i,
  input logic       start_o,
  input logic [1:0] src_o,
  input logic       ctl_ready_o,
  input logic       txn_ready_o,
  input logic       gate_open
);
  logic last_pkt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_pkt_q <= 1'b0;
    else if (start_o) last_pkt_q <= (src_o == 2'd1) || (src_o == 2'd2) ||
                                    (last_pkt_q && src_o == 2'd3);
  end

  // R2
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R2
  src_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> $stable(src_o));
  // R9
  ctl_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_ready_o |-> (start_o && src_o == 2'd1));
  // R9
  txn_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_ready_o |-> (start_o && src_o == 2'd2));
  // R8
  link_down_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !$past(link_up_i)) |-> src_o == 2'd0);
  // R3
  txn_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && src_o == 2'd2) |-> $past(gate_open));
  // R6
  idle_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && (src_o == 2'd1 || src_o == 2'd2)) |-> !last_pkt_q);
endmodule

bind tx_src_arb tx_src_arb_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .link_up_i   (link_up_i),
  .start_o     (start_o),
  .src_o       (src_o),
  .ctl_ready_o (ctl_ready_o),
  .txn_ready_o (txn_ready_o),
  .gate_open   (gate_open)
);

// File: tb/tb_tx_src_arb.sv
`timescale 1ns/1ps
module tb_tx_src_arb;
  localparam int SKP_IV = 50;
  localparam int GATE   = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic link_up_i = 1'b0, sym_tick_i = 1'b0, done_i = 1'b0;
  logic ctl_valid_i = 1'b0, txn_valid_i = 1'b0;
  logic ctl_ready_o, txn_ready_o, start_o;
  logic [1:0] src_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  tx_src_arb #(.SKP_INTERVAL(SKP_IV), .CTL_GATE(GATE)) dut (.*);

  int checks = 0, errors = 0;
  int c_pend = 0, t_pend = 0;
  int dly = 2, tmr = 0;
  bit hold_done = 0, tick_en = 1;
  int cyc = 0;

  // reference model state
  bit m_busy, m_start, m_owed, m_turn_txn;
  int m_src, m_cnt, m_gate;
  string m_tag = "R1";
  int n_skp = 0, n_txn = 0, n_ctl = 0, n_keep = 0, n_nonidle = 0, pkt_viol = 0;
  bit obs_last_pkt = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_start = 0; m_owed = 0; m_turn_txn = 1;
      m_src = 0; m_cnt = 0; m_gate = 0;
    end else begin
      bit dec, skp_now;
      if (m_start && m_src == 1) c_pend--;  // R9 pop
      if (m_start && m_src == 2) t_pend--;
      dec = !m_busy || (done_i && !m_start);
      skp_now = 0;
      if (dec) begin
        m_busy = 1;
        if (!link_up_i) begin m_src = 0; m_tag = "R8"; end
        else if (m_cnt >= SKP_IV) begin m_src = 3; m_tag = "R7"; skp_now = 1; end
        else if (m_owed) begin m_src = 0; m_owed = 0; m_tag = "R6"; end
        else if (m_gate < GATE) begin
          m_src = ctl_valid_i ? 1 : 0; m_tag = "R3";
        end else if (m_turn_txn) begin
          if (txn_valid_i) begin m_src = 2; m_turn_txn = 0; m_tag = "R4"; end
          else if (ctl_valid_i) begin m_src = 1; m_tag = "R5"; n_keep++; end
          else begin m_src = 0; m_tag = "R4"; end
        end else begin
          if (ctl_valid_i) begin m_src = 1; m_turn_txn = 1; m_tag = "R4"; end
          else if (txn_valid_i) begin m_src = 2; m_tag = "R5"; n_keep++; end
          else begin m_src = 0; m_tag = "R4"; end
        end
        if (m_src == 1 || m_src == 2) m_owed = 1;
        if (m_src == 1 && m_gate < GATE) m_gate++;
      end
      if (skp_now || !link_up_i) m_cnt = 0;
      else if (sym_tick_i && m_cnt < SKP_IV) m_cnt++;
      if (!link_up_i) begin m_owed = 0; m_gate = 0; m_turn_txn = 1; end
      m_start = dec;
    end
  end

  // drivers: 2 ns after each rising edge
  always @(posedge clk_i) begin
    #2;
    cyc++;
    ctl_valid_i = (c_pend > 0);
    txn_valid_i = (t_pend > 0);
    sym_tick_i  = tick_en && (cyc % 3 != 0);
    if (hold_done) done_i = 1'b1;
    else if (start_o) begin tmr = dly; done_i = 1'b0; end
    else if (tmr > 0) begin tmr--; done_i = (tmr == 0); end
    else done_i = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // comparisons at the falling edge
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      chk(!start_o && !ctl_ready_o && !txn_ready_o, "R1", {start_o, ctl_ready_o, txn_ready_o}, 0);
    end else begin
      chk(start_o == m_start, "R2", start_o, m_start);
      if (m_start) chk(int'(src_o) == m_src, m_tag, src_o, m_src);
      chk(ctl_ready_o == (m_start && m_src == 1), "R9", ctl_ready_o, m_start && m_src == 1);
      chk(txn_ready_o == (m_start && m_src == 2), "R9", txn_ready_o, m_start && m_src == 2);
      if (start_o) begin
        if (src_o == 2'd3) n_skp++;
        if (src_o == 2'd2) n_txn++;
        if (src_o == 2'd1) n_ctl++;
        if (src_o != 2'd0) n_nonidle++;
        if ((src_o == 2'd1 || src_o == 2'd2) && obs_last_pkt) pkt_viol++;
        if (src_o == 2'd0) obs_last_pkt = 0;
        else if (src_o != 2'd3) obs_last_pkt = 1;
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    // R8: link down, traffic offered, only idle frames
    c_pend = 2; t_pend = 2; n_nonidle = 0;
    run(60);
    chk(n_nonidle == 0, "R8", n_nonidle, 0);
    c_pend = 0; t_pend = 0;
    run(4);
    // R3: gate holds transaction packets
    link_up_i = 1'b1; n_ctl = 0; n_txn = 0;
    c_pend = 3; t_pend = 4;
    run(80);
    chk(n_ctl == 3, "R3", n_ctl, 3);
    chk(n_txn == 0, "R3", n_txn, 0);
    c_pend += 2;
    run(120);
    chk(n_ctl == 5, "R3", n_ctl, 5);
    chk(n_txn == 4, "R4", n_txn, 4);
    // sweep of queue fills and framer latencies
    for (int p = 0; p < 48; p++) begin
      c_pend += p % 4;
      t_pend += (p / 4) % 4;
      dly = 1 + p % 4;
      hold_done = (p % 7 == 3);
      run(40);
    end
    hold_done = 0;
    // link drop mid-traffic, then re-gate
    c_pend += 4; t_pend += 4;
    run(6);
    link_up_i = 1'b0;
    run(40);
    link_up_i = 1'b1; n_txn = 0; n_ctl = 0;
    run(300);
    chk(n_ctl >= GATE, "R8", n_ctl, GATE);
    chk(pkt_viol == 0, "R6", pkt_viol, 0);
    chk(n_skp > 0, "R7", n_skp, 1);
    chk(n_keep > 0, "R5", n_keep, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule